// File: doc/BRIEF.md
# Indirect Configuration Register Window

This block gives a host indirect access to a small bank of 8-bit configuration slots through two host locations. The first holds a selector whose three low bits pick a target offset. The second is a window: reads and writes there reach whichever slot the selector currently points at. Only four offsets hold a slot. A window access at any other offset does nothing.

The pair answers only while the `cfgEnable` input is high. While it is low, host writes are dropped and host reads return zero. The slot contents are not interpreted here. They are held and driven out on one flat bus for the logic that uses them. A slot returns to its parameterised default only on a hardware reset. Dropping and raising `cfgEnable` does not clear it.

Top module: `cfg_index_port`

## Requirements
- R1: While `rstN` is low, and right after reset, the selector reads 00h and each slot holds its `RESET_VALS` byte. Slot k is taken from bits [8k+7:8k].
- R2: A selector write (`hostSel`=0) keeps only data bits 2:0. A selector read returns those three bits in 2:0, with bits 7:3 always zero.
- R3: A window write (`hostSel`=1) at offset 0, 2, 4 or 5 loads the data into slot 0, 1, 2 or 3 respectively. The new value appears on `bankOut` bits [8k+7:8k] in the cycle after the write edge. No other slot changes.
- R4: A window read at offset 0, 2, 4 or 5 returns the current content of the matching slot, in the same cycle as the read strobe.
- R5: A window write at offset 1, 3, 6 or 7 leaves every slot and the selector unchanged.
- R6: A window read at offset 1, 3, 6 or 7 returns 00h.
- R7: Selector bits 7:3 play no part in decoding. Writing a selector value v gives exactly the behaviour of writing v & 07h.
- R8: While `cfgEnable` is 0, writes to either location change neither the selector nor any slot, and reads of either location return 00h. Slot contents survive a disable and re-enable.
- R9: `hostRdata` is 00h in any cycle without a `hostRd` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| cfgEnable | input | 1 | Opens the selector/window pair to host access |
| hostSel | input | 1 | 0 selects the selector location, 1 the window |
| hostWr | input | 1 | Host write strobe, one cycle per write |
| hostRd | input | 1 | Host read strobe; read data is combinational |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data, zero when no read is decoded |
| bankOut | output | 32 | All slots side by side; slot k in bits [8k+7:8k] |

## Verification
The hardest case to reach is a selector that was written with nonzero high bits and that lands on an unimplemented offset just after a slot was changed. Only then does a stray write or a wrong readback show up. The bench sweeps all 256 selector values. After each one it writes the window with a value derived from the selector and compares every slot against a model. Offset aliasing, sparse decoding and upper-bit masking are therefore each covered many times. A final pass repeats the accesses with `cfgEnable` low and then checks that the earlier state survived.

// File: rtl/cfgidx_pkg.sv
`timescale 1ns/1ps
package cfgidx_pkg;

  // Offset field width and number of implemented slots.
  localparam int OFF_W   = 3;
  localparam int SLOTS   = 4;
  localparam int SLOT_IW = $clog2(SLOTS);

  // Strobes from the decoder to the register datapath.
  typedef struct packed {
    logic               idxWr;
    logic               idxRd;
    logic               slotWr;
    logic               slotRd;
    logic [SLOT_IW-1:0] slot;
  } cfgStrobe_t;

  typedef struct packed {
    logic               hit;
    logic [SLOT_IW-1:0] slot;
  } slotHit_t;

  // Sparse map: offsets 0,2,4,5 hold slots 0..3, all others are empty.
  function automatic slotHit_t decodeOffset(input logic [OFF_W-1:0] off);
    slotHit_t r;
    r.hit  = 1'b0;
    r.slot = '0;
    case (off)
      3'd0: begin r.hit = 1'b1; r.slot = 2'd0; end
      3'd2: begin r.hit = 1'b1; r.slot = 2'd1; end
      3'd4: begin r.hit = 1'b1; r.slot = 2'd2; end
      3'd5: begin r.hit = 1'b1; r.slot = 2'd3; end
      default: begin r.hit = 1'b0; r.slot = '0; end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cfgidx_ctrl.sv
`timescale 1ns/1ps
module cfgidx_ctrl
  import cfgidx_pkg::*;
(
  input  logic             cfgEnable,
  input  logic             hostSel,
  input  logic             hostWr,
  input  logic             hostRd,
  input  logic [OFF_W-1:0] idxOff,
  output cfgStrobe_t       strb
);

  slotHit_t hitInfo;
  logic     wrOk;
  logic     rdOk;

  always_comb begin
    hitInfo = decodeOffset(idxOff);
    wrOk    = cfgEnable & hostWr;
    rdOk    = cfgEnable & hostRd;

    strb.idxWr  = wrOk & ~hostSel;
    strb.idxRd  = rdOk & ~hostSel;
    strb.slotWr = wrOk &  hostSel & hitInfo.hit;
    strb.slotRd = rdOk &  hostSel & hitInfo.hit;
    strb.slot   = hitInfo.slot;
  end

endmodule

// File: rtl/cfgidx_dp.sv
`timescale 1ns/1ps
module cfgidx_dp
  import cfgidx_pkg::*;
#(
  parameter int                    DATA_W     = 8,
  parameter logic [SLOTS*DATA_W-1:0] RESET_VALS = '0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cfgStrobe_t              strb,
  input  logic [DATA_W-1:0]       wdata,
  output logic [OFF_W-1:0]        idxOff,
  output logic [DATA_W-1:0]       rdata,
  output logic [SLOTS*DATA_W-1:0] bankOut
);

  localparam int PAD_W = DATA_W - OFF_W;

  logic [OFF_W-1:0]  idxQ;
  logic [DATA_W-1:0] slotQ [SLOTS];

  // Selector: only the offset field is stored.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           idxQ <= '0;
    else if (strb.idxWr) idxQ <= wdata[OFF_W-1:0];
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        slotQ[k] <= RESET_VALS[k*DATA_W +: DATA_W];
      else if (strb.slotWr && (strb.slot == SLOT_IW'(k)))
        slotQ[k] <= wdata;
    end
    assign bankOut[k*DATA_W +: DATA_W] = slotQ[k];
  end

  always_comb begin
    rdata = '0;
    if (strb.idxRd)       rdata = {{PAD_W{1'b0}}, idxQ};
    else if (strb.slotRd) rdata = slotQ[strb.slot];
  end

  assign idxOff = idxQ;

endmodule

// File: rtl/cfg_index_port.sv
`timescale 1ns/1ps
module cfg_index_port
  import cfgidx_pkg::*;
#(
  parameter int                      DATA_W     = 8,
  parameter logic [SLOTS*DATA_W-1:0] RESET_VALS = 32'hA5_3C_81_00
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgEnable,
  input  logic                    hostSel,
  input  logic                    hostWr,
  input  logic                    hostRd,
  input  logic [DATA_W-1:0]       hostWdata,
  output logic [DATA_W-1:0]       hostRdata,
  output logic [SLOTS*DATA_W-1:0] bankOut
);

  cfgStrobe_t       strb;
  logic [OFF_W-1:0] idxOff;

  cfgidx_ctrl u_ctrl (
    .cfgEnable (cfgEnable),
    .hostSel   (hostSel),
    .hostWr    (hostWr),
    .hostRd    (hostRd),
    .idxOff    (idxOff),
    .strb      (strb)
  );

  cfgidx_dp #(
    .DATA_W     (DATA_W),
    .RESET_VALS (RESET_VALS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wdata   (hostWdata),
    .idxOff  (idxOff),
    .rdata   (hostRdata),
    .bankOut (bankOut)
  );

endmodule

// File: rtl/cfgidx_chk.sv
`timescale 1ns/1ps
module cfgidx_chk #(
  parameter int DATA_W = 8,
  parameter int SLOTS  = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    cfgEnable,
  input logic                    hostSel,
  input logic                    hostWr,
  input logic                    hostRd,
  input logic [DATA_W-1:0]       hostWdata,
  input logic [DATA_W-1:0]       hostRdata,
  input logic [SLOTS*DATA_W-1:0] bankOut,
  input logic [2:0]              idxOff
);

  logic emptyOff;
  assign emptyOff = (idxOff == 3'd1) || (idxOff == 3'd3) ||
                    (idxOff == 3'd6) || (idxOff == 3'd7);

  // R2
  idx_read_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && hostRd && !hostSel) |-> (hostRdata[DATA_W-1:3] == '0));

  // R3
  slot2_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && hostWr && hostSel && idxOff == 3'd4)
      |=> (bankOut[2*DATA_W +: DATA_W] == $past(hostWdata)));

  // R5
  empty_write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && hostWr && hostSel && emptyOff)
      |=> ($stable(bankOut) && $stable(idxOff)));

  // R6
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && hostRd && hostSel && emptyOff) |-> (hostRdata == '0));

  // R8
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEnable) |=> ($stable(bankOut) && $stable(idxOff)));

  // R8
  disabled_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEnable) |-> (hostRdata == '0));

  // R9
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hostRd) |-> (hostRdata == '0));

endmodule

bind cfg_index_port cfgidx_chk #(
  .DATA_W (DATA_W),
  .SLOTS  (cfgidx_pkg::SLOTS)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .cfgEnable (cfgEnable),
  .hostSel   (hostSel),
  .hostWr    (hostWr),
  .hostRd    (hostRd),
  .hostWdata (hostWdata),
  .hostRdata (hostRdata),
  .bankOut   (bankOut),
  .idxOff    (idxOff)
);

// File: tb/cfg_index_port_tb.sv
`timescale 1ns/1ps
module cfg_index_port_tb_top;

  localparam logic [31:0] RST_VALS = 32'hA5_3C_81_00;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgEnable = 1'b0;
  logic        hostSel = 1'b0;
  logic        hostWr = 1'b0;
  logic        hostRd = 1'b0;
  logic [7:0]  hostWdata = '0;
  logic [7:0]  hostRdata;
  logic [31:0] bankOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] model [4];
  logic [2:0] modelIdx;

  always #10 clk = ~clk;

  cfg_index_port #(.DATA_W(8), .RESET_VALS(RST_VALS)) dut_i (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .hostSel(hostSel),
    .hostWr(hostWr), .hostRd(hostRd), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .bankOut(bankOut)
  );

  function automatic int slotFor(input logic [2:0] off);
    case (off)
      3'd0: return 0;
      3'd2: return 1;
      3'd4: return 2;
      3'd5: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] modelBus();
    return {model[3], model[2], model[1], model[0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic sel, input logic [7:0] d);
    @(negedge clk);
    hostSel = sel; hostWdata = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic doRead(input logic sel, output logic [7:0] d);
    @(negedge clk);
    hostSel = sel; hostRd = 1'b1;
    #5 d = hostRdata;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic resetModel();
    for (int k = 0; k < 4; k++) model[k] = RST_VALS[k*8 +: 8];
    modelIdx = '0;
  endtask

  initial begin
    logic [7:0] rd;
    resetModel();
    #35;
    // R1: values held during reset
    chk("R1 bank during reset", bankOut, modelBus());
    rstN = 1'b1;
    cfgEnable = 1'b1;
    doRead(1'b0, rd);
    chk("R1 selector after reset", {24'h0, rd}, 32'h0);
    chk("R1 bank after reset", bankOut, modelBus());
    #5 chk("R9 idle read data", {24'h0, hostRdata}, 32'h0);

    // Sweep every selector value with a window write and read each time.
    for (int iv = 0; iv < 256; iv++) begin
      logic [7:0] dv;
      int s;
      dv = 8'(iv) ^ 8'h96;
      doWrite(1'b0, 8'(iv));
      modelIdx = 3'(iv & 7);
      doRead(1'b0, rd);
      chk("R2 selector readback", {24'h0, rd}, {29'h0, modelIdx});
      doWrite(1'b1, dv);
      s = slotFor(modelIdx);
      if (s >= 0) model[s] = dv;
      if (s >= 0) chk("R3/R7 bank after window write", bankOut, modelBus());
      else        chk("R5 bank after empty-offset write", bankOut, modelBus());
      doRead(1'b1, rd);
      if (s >= 0) chk("R4 window read", {24'h0, rd}, {24'h0, model[s]});
      else        chk("R6 empty-offset read", {24'h0, rd}, 32'h0);
      doRead(1'b0, rd);
      chk("R5/R7 selector kept after window access", {24'h0, rd}, {29'h0, modelIdx});
      #5 chk("R9 idle read data", {24'h0, hostRdata}, 32'h0);
    end

    // Leave the selector on a live slot, then disable the pair.
    doWrite(1'b0, 8'hF9); // offset 1 after masking
    doWrite(1'b0, 8'hFD); // offset 5
    modelIdx = 3'd5;
    cfgEnable = 1'b0;
    for (int iv = 0; iv < 32; iv++) begin
      doWrite(1'b0, 8'(iv * 7));
      doWrite(1'b1, 8'(iv * 13 + 1));
      chk("R8 bank held while disabled", bankOut, modelBus());
      doRead(1'b0, rd);
      chk("R8 selector read zero while disabled", {24'h0, rd}, 32'h0);
      doRead(1'b1, rd);
      chk("R8 window read zero while disabled", {24'h0, rd}, 32'h0);
    end
    cfgEnable = 1'b1;
    doRead(1'b0, rd);
    chk("R8 selector survives disable", {24'h0, rd}, {29'h0, modelIdx});
    doRead(1'b1, rd);
    chk("R8 slot survives disable", {24'h0, rd}, {24'h0, model[3]});
    chk("R8 bank survives re-enable", bankOut, modelBus());

    // A second hardware reset restores the defaults.
    @(negedge clk);
    rstN = 1'b0;
    resetModel();
    #5 chk("R1 bank after second reset", bankOut, modelBus());
    @(negedge clk);
    rstN = 1'b1;
    doRead(1'b0, rd);
    chk("R1 selector after second reset", {24'h0, rd}, 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule